// File: doc/BRIEF.md
# Digital I/O Register File

This block is the register file of a 56-line digital I/O peripheral. A host reaches it through a simple synchronous bus: a 4-bit byte address, 8-bit write data with a write strobe, and 8-bit read data that follows the address combinationally. Behind the bus sit three byte latches that drive 24 dedicated output lines, a synchronizer that samples 24 dedicated input lines, and one 8-line bank whose direction is chosen by a control bit. In output mode that bank drives its own latch onto the lines. In input mode its lines are sampled and can be read.

A separate change-of-state detector consumes the enable byte held here. It also takes a one-cycle reset pulse, and it returns its interrupt pin level so that software can read it. Writing any value to the top address performs a software reset. This clears the output latches and the control register, which returns the shared bank to input mode.

Top module: `dio_regfile`

## Requirements
- R1: After the reset input is released, `ded_out`, `shr_out`, `shr_oe`, `cos_en` and `det_rst` are all zero, and the latch addresses 0, 1, 2, 3, 12 and 14 read back zero.
- R2: A write to address 0, 1 or 2 loads lines 7..0, 15..8 or 23..16 of `ded_out` at the next clock edge. A read of the same address returns that byte.
- R3: A read of address 4, 5 or 6 returns `ded_in` bits 7..0, 15..8 or 23..16, delayed by two clock edges through a two-stage synchronizer. After only one edge the read still returns the old value.
- R4: A write to address 4, 5, 6 or 7 changes no output and no readable register.
- R5: Bit 1 of the control register at address 12 drives `shr_oe`, where 1 means output. `shr_oe` changes in the same cycle as the register. The whole control byte reads back at address 12.
- R6: Address 3 holds the shared-bank latch, which drives `shr_out` and reads back. The latch accepts writes in either mode and keeps its value when the direction changes.
- R7: A read of address 7 returns `shr_in` after the same two-edge synchronizer delay as R3.
- R8: Address 14 holds the change-of-state enable byte. It reads back, appears on `cos_en`, and is not cleared by a software reset.
- R9: A write to address 15 clears the three output latches, the shared latch and the control register at the next edge. It also raises `det_rst` for exactly one cycle after that edge.
- R10: A read of address 15 returns `irq_level` in bit 0 and zeros in bits 7..1.
- R11: Addresses 8, 9, 10, 11 and 13 read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| addr | input | 4 | Byte address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| ded_out | output | 24 | Dedicated output lines |
| ded_in | input | 24 | Dedicated input lines, asynchronous |
| shr_out | output | 8 | Shared-bank output latch value |
| shr_oe | output | 1 | Shared-bank output enable |
| shr_in | input | 8 | Shared-bank input lines, asynchronous |
| cos_en | output | 8 | Change-of-state enable byte to the detector |
| det_rst | output | 1 | One-cycle reset pulse to the detector |
| irq_level | input | 1 | Interrupt pin level from the detector |

## Verification
Every latch address is swept with all 256 byte values, and a fixed pattern is kept in the other lanes. A wrong lane or a stuck bit then shows up as a mismatch on both the line outputs and the readback. Each input group is swept with all 256 values while the other groups hold a fixed pattern. This exposes a swapped group, and a check taken after one edge separates a two-stage delay from a shorter one. Writes to the read-only, unused and reserved addresses use values that would be visible if they landed. The software reset is issued with every latch, the control byte and the enable byte non-zero. This tells apart what it clears, what it keeps, and how long the detector pulse lasts.

// File: rtl/dio_pkg.sv
package dio_pkg;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DED_BYTES = 3;
    localparam int DIR_BIT = 1;

    localparam logic [AW-1:0] A_OUT_BASE = 4'd0;
    localparam logic [AW-1:0] A_SHR_LAT  = 4'd3;
    localparam logic [AW-1:0] A_IN_BASE  = 4'd4;
    localparam logic [AW-1:0] A_SHR_IN   = 4'd7;
    localparam logic [AW-1:0] A_CTL      = 4'd12;
    localparam logic [AW-1:0] A_COS_EN   = 4'd14;
    localparam logic [AW-1:0] A_SRST     = 4'd15;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef logic [STAGES-1:0][W-1:0] chain_t;
    chain_t chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/dio_ctrl_regs.sv
module dio_ctrl_regs
    import dio_pkg::*;
#(
    parameter int NB = DED_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wr_data,
    output logic [NB-1:0][DW-1:0] out_lat,
    output logic [DW-1:0]        shr_lat,
    output logic [DW-1:0]        ctl,
    output logic [DW-1:0]        cos,
    output logic                 det_rst
);
    typedef struct packed {
        logic [NB-1:0][DW-1:0] outs;
        logic [DW-1:0]         shr;
        logic [DW-1:0]         ctl;
        logic [DW-1:0]         cos;
        logic                  srst;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.srst = 1'b0;
        if (wr_en) begin
            for (int i = 0; i < NB; i++)
                if (addr == A_OUT_BASE + AW'(i)) r_d.outs[i] = wr_data;
            if (addr == A_SHR_LAT) r_d.shr = wr_data;
            if (addr == A_CTL)     r_d.ctl = wr_data;
            if (addr == A_COS_EN)  r_d.cos = wr_data;
            if (addr == A_SRST) begin
                r_d.outs = '0;
                r_d.shr  = '0;
                r_d.ctl  = '0;
                r_d.srst = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_lat = r_q.outs;
    assign shr_lat = r_q.shr;
    assign ctl     = r_q.ctl;
    assign cos     = r_q.cos;
    assign det_rst = r_q.srst;

    // R2
    lane0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_OUT_BASE) |=> out_lat[0] == $past(wr_data));

    // R4
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= A_IN_BASE && addr <= A_SHR_IN)
        |=> ($stable(out_lat) && $stable(shr_lat) && $stable(ctl) && $stable(cos)));

    // R6
    shr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == A_SHR_LAT || addr == A_SRST)) |=> $stable(shr_lat));

    // R9
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SRST) |=> (out_lat == '0 && ctl == '0 && det_rst && $stable(cos)));
endmodule

// File: rtl/dio_rd_mux.sv
module dio_rd_mux
    import dio_pkg::*;
#(
    parameter int NB = DED_BYTES
) (
    input  logic [AW-1:0]         addr,
    input  logic [NB-1:0][DW-1:0] out_lat,
    input  logic [DW-1:0]         shr_lat,
    input  logic [DW-1:0]         ctl,
    input  logic [DW-1:0]         cos,
    input  logic [NB-1:0][DW-1:0] in_sync,
    input  logic [DW-1:0]         shr_sync,
    input  logic                  irq_level,
    output logic [DW-1:0]         rd_data
);
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NB; i++) begin
            if (addr == A_OUT_BASE + AW'(i)) rd_data = out_lat[i];
            if (addr == A_IN_BASE + AW'(i))  rd_data = in_sync[i];
        end
        if (addr == A_SHR_LAT) rd_data = shr_lat;
        if (addr == A_SHR_IN)  rd_data = shr_sync;
        if (addr == A_CTL)     rd_data = ctl;
        if (addr == A_COS_EN)  rd_data = cos;
        if (addr == A_SRST)    rd_data = {{(DW-1){1'b0}}, irq_level};
    end
endmodule

// File: rtl/dio_regfile.sv
module dio_regfile
    import dio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [3:0]            addr,
    input  logic [7:0]            wr_data,
    output logic [7:0]            rd_data,
    output logic [23:0]           ded_out,
    input  logic [23:0]           ded_in,
    output logic [7:0]            shr_out,
    output logic                  shr_oe,
    input  logic [7:0]            shr_in,
    output logic [7:0]            cos_en,
    output logic                  det_rst,
    input  logic                  irq_level
);
    localparam int NB = DED_BYTES;
    localparam int DED_W = NB * DW;

    logic [NB-1:0][DW-1:0] out_lat;
    logic [NB-1:0][DW-1:0] in_sync;
    logic [DED_W-1:0]      in_sync_flat;
    logic [DW-1:0]         shr_lat, ctl, shr_sync;

    dio_sync #(.W(DED_W), .STAGES(SYNC_STAGES)) u_sync_ded (
        .clk(clk), .rst_n(rst_n), .din(ded_in), .dout(in_sync_flat));

    dio_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync_shr (
        .clk(clk), .rst_n(rst_n), .din(shr_in), .dout(shr_sync));

    assign in_sync = in_sync_flat;

    dio_ctrl_regs #(.NB(NB)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .out_lat(out_lat), .shr_lat(shr_lat), .ctl(ctl), .cos(cos_en),
        .det_rst(det_rst));

    dio_rd_mux #(.NB(NB)) u_rd (
        .addr(addr), .out_lat(out_lat), .shr_lat(shr_lat), .ctl(ctl), .cos(cos_en),
        .in_sync(in_sync), .shr_sync(shr_sync), .irq_level(irq_level),
        .rd_data(rd_data));

    assign ded_out = out_lat;
    assign shr_out = shr_lat;
    assign shr_oe  = ctl[DIR_BIT];

    // R5
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shr_oe) |-> $past(wr_en && addr == A_CTL && wr_data[DIR_BIT]));

    // R10
    irq_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_SRST) |-> (rd_data == {7'd0, irq_level}));
endmodule

// File: tb/dio_regfile_tb.sv
module dio_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [7:0]  rd_data;
    logic [23:0] ded_out;
    logic [23:0] ded_in = 24'd0;
    logic [7:0]  shr_out;
    logic        shr_oe;
    logic [7:0]  shr_in = 8'd0;
    logic [7:0]  cos_en;
    logic        det_rst;
    logic        irq_level = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] r;

    always #10 clk = ~clk;

    dio_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .ded_out(ded_out), .ded_in(ded_in), .shr_out(shr_out),
        .shr_oe(shr_oe), .shr_in(shr_in), .cos_en(cos_en), .det_rst(det_rst),
        .irq_level(irq_level));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 ded_out", ded_out, 0);
        chk("R1 shr_out", shr_out, 0);
        chk("R1 shr_oe", shr_oe, 0);
        chk("R1 cos_en", cos_en, 0);
        chk("R1 det_rst", det_rst, 0);
        foreach (r[i]) begin end
        for (int a = 0; a < 16; a++) begin
            if (a == 0 || a == 1 || a == 2 || a == 3 || a == 12 || a == 14) begin
                rd(4'(a), r);
                chk("R1 latch read", r, 0);
            end
        end

        // R2 exhaustive per lane, other lanes hold a pattern
        wr(4'd0, 8'h3C); wr(4'd1, 8'hC3); wr(4'd2, 8'h69);
        for (int g = 0; g < 3; g++) begin
            for (int v = 0; v < 256; v++) begin
                logic [23:0] e;
                e = 24'h69C33C;
                e[g*8 +: 8] = 8'(v);
                wr(4'(g), 8'(v));
                chk("R2 ded_out", ded_out, e);
                rd(4'(g), r);
                chk("R2 readback", r, v);
            end
            wr(4'(g), 8'((24'h69C33C >> (g*8)) & 8'hFF));
        end

        // R3 exhaustive input groups with two-edge delay
        ded_in = 24'h5AA55A;
        repeat (2) @(negedge clk);
        for (int g = 0; g < 3; g++) begin
            for (int v = 0; v < 256; v++) begin
                logic [23:0] e;
                e = 24'h5AA55A;
                e[g*8 +: 8] = 8'(v);
                ded_in = e;
                @(negedge clk); #1;
                if (v == 8'h5A || v == 8'hA5) begin end
                else begin
                    rd(4'(4 + g), r);
                    chk("R3 not after one edge", r, (24'h5AA55A >> (g*8)) & 8'hFF);
                end
                @(negedge clk); #1;
                rd(4'(4 + g), r);
                chk("R3 input read", r, v);
                ded_in = 24'h5AA55A;
                repeat (2) @(negedge clk);
            end
        end

        // R7 shared input
        for (int v = 0; v < 256; v += 17) begin
            shr_in = 8'(v);
            repeat (2) @(negedge clk); #1;
            rd(4'd7, r);
            chk("R7 shared input read", r, v);
        end

        // R6 / R5 shared bank
        wr(4'd3, 8'hB7);
        chk("R6 shr_out in input mode", shr_out, 8'hB7);
        chk("R5 oe low", shr_oe, 0);
        wr(4'd12, 8'h02);
        chk("R5 oe high", shr_oe, 1);
        chk("R6 latch kept on mode change", shr_out, 8'hB7);
        rd(4'd12, r); chk("R5 ctl readback", r, 8'h02);
        wr(4'd12, 8'hFD);
        chk("R5 oe low with other bits set", shr_oe, 0);
        rd(4'd12, r); chk("R5 ctl readback full", r, 8'hFD);
        chk("R6 latch kept after return", shr_out, 8'hB7);
        wr(4'd3, 8'h4E);
        rd(4'd3, r); chk("R6 readback", r, 8'h4E);

        // R8 enable byte
        wr(4'd14, 8'hA3);
        chk("R8 cos_en", cos_en, 8'hA3);
        rd(4'd14, r); chk("R8 readback", r, 8'hA3);

        // R4 / R11 ignored writes
        wr(4'd12, 8'h06);
        for (int a = 4; a < 14; a++) begin
            if (a == 12) continue;
            wr(4'(a), 8'hFF);
            chk("R4 R11 ded_out unchanged", ded_out, 24'h69C33C);
            chk("R4 R11 shr_out unchanged", shr_out, 8'h4E);
            chk("R4 R11 shr_oe unchanged", shr_oe, 1);
            chk("R4 R11 cos_en unchanged", cos_en, 8'hA3);
            rd(4'd12, r); chk("R4 R11 ctl unchanged", r, 8'h06);
            if (a >= 8) begin
                rd(4'(a), r); chk("R11 reads zero", r, 0);
            end
        end
        rd(4'd5, r); chk("R4 input unaffected", r, 8'hA5);

        // R10 interrupt level
        irq_level = 1'b1; rd(4'd15, r); chk("R10 irq high", r, 8'h01);
        irq_level = 1'b0; rd(4'd15, r); chk("R10 irq low", r, 8'h00);

        // R9 software reset
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd15; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0; #1;
        chk("R9 det_rst pulse", det_rst, 1);
        chk("R9 ded_out cleared", ded_out, 0);
        chk("R9 shr_out cleared", shr_out, 0);
        chk("R9 shr_oe cleared", shr_oe, 0);
        chk("R9 cos_en kept", cos_en, 8'hA3);
        rd(4'd12, r); chk("R9 ctl cleared", r, 0);
        @(negedge clk); #1;
        chk("R9 det_rst one cycle", det_rst, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule